// File: doc/BRIEF.md
# Audio Control Register Port over SPI

This block is a serial slave that gives a host processor access to a small bank of audio-control registers. The host frames each transaction by pulling chip select low. The first byte it sends is a command. The command carries a 4-bit register address and a direction flag. Every byte that follows in the same frame is data for one register. The first data byte goes to the commanded address, and the address steps up by one for each byte after that.

While the host shifts bytes in, the slave shifts a reply byte out on every byte. For the command byte, the reply is the external status byte. For read data bytes, the reply is the addressed register, unless that address has nothing readable behind it. For write data bytes, the reply is the status byte.

The register bank holds six attenuator settings, a per-channel mute mask, a clock/PLL setting and two serial-audio format settings. One write-only address updates all six attenuator registers at once. The mute register also shows a busy flag, which comes from an external input and cannot be written. All serial inputs are synchronised into the system clock domain. The serial clock is therefore expected to run well below the system clock.

Top module: `audio_ctl_spi`

## Requirements
- R1: The first complete byte after chip select falls is the command byte. Bits 4..1 are the address (bit 4 most significant) and bit 0 is the direction: 1 means write and 0 means read. Bits 7..5 are ignored. The direction holds for the whole frame.
- R2: Each write data byte is stored at the current address, and the address then steps up by one. The first data byte uses the command address. The address wraps from 15 to 0, and writes to addresses 0, 12, 13, 14 and 15 change nothing.
- R3: In a read frame, each data byte shifts out the register at the current address. The first data byte returns the commanded register, and later bytes return the following addresses in turn.
- R4: The reply is the value of `status_in` during the command byte and during every data byte of a write frame.
- R5: A read of address 0, 7, 12, 13, 14 or 15 returns the value of `status_in`.
- R6: A write to address 7 stores the byte into all six attenuator registers (addresses 1 to 6).
- R7: At address 8 (mute), bits 5..0 are channel mutes for channels 6..1, where 1 means muted. They are stored and driven on `mute_o`. On read, bit 6 is the `busy` input and bit 7 is 0. A write never changes what bit 6 reads.
- R8: If chip select rises part-way through a byte, that byte is dropped with no write. The next frame starts again with a command byte.
- R9: After reset every register is 0 and `miso` is 0. `miso` stays at 0 while chip select is high.
- R10: The port uses SPI mode 0 and shifts MSB first. MOSI is taken on the rising edge of `sck`. `miso` changes only after a falling edge of `sck` or a change of chip select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| csn | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial reply data to the host |
| status_in | input | 8 | Status byte sent on status replies |
| busy | input | 1 | Mute-in-progress flag, read at bit 6 of the mute register |
| att_o | output | 48 | Six attenuator registers, channel 1 in bits 7..0 |
| mute_o | output | 6 | Channel mute mask, channel 1 in bit 0 |
| clk_cfg_o | output | 8 | Clock/PLL register (address 9) |
| tx_fmt_o | output | 8 | Transmit format register (address 10) |
| rx_fmt_o | output | 8 | Receive format register (address 11) |

## Verification
The assertions assume that each `sck` level and each chip-select level lasts several system clocks longer than the synchroniser delay. They also assume that `sck` is low whenever chip select changes, as mode 0 requires. The bench drives each serial half period for eight system clocks and moves chip select only while `sck` is low. It holds `status_in` and `busy` steady throughout each frame, so that every reply byte has one defined expected value.

// File: rtl/spi_regs_pkg.sv
package spi_regs_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  typedef logic [DW-1:0] byte_t;
  typedef logic [AW-1:0] addr_t;

  localparam addr_t A_BCAST = 4'd7;
  localparam addr_t A_MUTE  = 4'd8;
  localparam addr_t A_CLK   = 4'd9;
  localparam addr_t A_TXF   = 4'd10;
  localparam addr_t A_RXF   = 4'd11;

  // registers that can return their own content
  function automatic logic has_content(addr_t a, addr_t last_att);
    return ((a >= 4'd1) && (a <= last_att)) || ((a >= A_MUTE) && (a <= A_RXF));
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic csn,
  input  logic mosi,
  output logic sck_rise,
  output logic sck_fall,
  output logic cs_active,
  output logic cs_fall,
  output logic mosi_s
);
  logic [STAGES-1:0] sck_ch, csn_ch, mosi_ch;
  logic sck_d, act_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_ch  <= '0;
      csn_ch  <= '1;
      mosi_ch <= '0;
      sck_d   <= 1'b0;
      act_d   <= 1'b0;
    end else begin
      sck_ch  <= {sck_ch[STAGES-2:0], sck};
      csn_ch  <= {csn_ch[STAGES-2:0], csn};
      mosi_ch <= {mosi_ch[STAGES-2:0], mosi};
      sck_d   <= sck_ch[STAGES-1];
      act_d   <= ~csn_ch[STAGES-1];
    end
  end

  assign sck_rise  = sck_ch[STAGES-1] & ~sck_d;
  assign sck_fall  = ~sck_ch[STAGES-1] & sck_d;
  assign cs_active = ~csn_ch[STAGES-1];
  assign cs_fall   = cs_active & ~act_d;
  assign mosi_s    = mosi_ch[STAGES-1];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_active,
  input  logic  cs_fall,
  input  logic  sck_rise,
  input  logic  sck_fall,
  input  logic  mosi_s,
  input  byte_t reply,
  output logic  byte_done,
  output byte_t rx_byte,
  output logic  miso
);
  localparam int CW = $clog2(DW);

  logic [CW-1:0] bitcnt;
  byte_t rx_sh, tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      byte_done <= 1'b0;
      miso      <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!cs_active) begin
        bitcnt <= '0;
        miso   <= 1'b0;
      end else if (cs_fall) begin
        bitcnt <= '0;
        tx_sh  <= reply;
        miso   <= reply[DW-1];
      end else begin
        if (sck_rise) begin
          rx_sh  <= {rx_sh[DW-2:0], mosi_s};
          bitcnt <= bitcnt + 1'b1;
          if (bitcnt == CW'(DW-1)) begin
            rx_byte   <= {rx_sh[DW-2:0], mosi_s};
            byte_done <= 1'b1;
          end
        end
        if (sck_fall) begin
          if (bitcnt == '0) begin
            tx_sh <= reply;
            miso  <= reply[DW-1];
          end else begin
            tx_sh <= {tx_sh[DW-2:0], 1'b0};
            miso  <= tx_sh[DW-2];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_ctl.sv
module spi_frame_ctl
  import spi_regs_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  cs_active,
  input  logic  byte_done,
  input  byte_t rx_byte,
  input  byte_t status_in,
  input  byte_t rd_data,
  input  logic  rd_ok,
  output addr_t ptr,
  output logic  wr_stb,
  output byte_t wr_data,
  output byte_t reply
);
  logic first_q, wr_q;

  always_ff @(posedge clk) begin
    if (rst || !cs_active) begin
      first_q <= 1'b1;
      wr_q    <= 1'b0;
      ptr     <= '0;
    end else if (byte_done) begin
      if (first_q) begin
        first_q <= 1'b0;
        wr_q    <= rx_byte[0];
        ptr     <= rx_byte[AW:1];
      end else begin
        ptr <= ptr + 1'b1;
      end
    end
  end

  assign wr_stb  = byte_done & ~first_q & wr_q;
  assign wr_data = rx_byte;
  assign reply   = (first_q || wr_q || !rd_ok) ? status_in : rd_data;
endmodule

// File: rtl/audio_reg_bank.sv
module audio_reg_bank
  import spi_regs_pkg::*;
#(
  parameter int NUM_ATT = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_stb,
  input  addr_t                 addr,
  input  byte_t                 wr_data,
  input  logic                  busy,
  output byte_t                 rd_data,
  output logic                  rd_ok,
  output logic [NUM_ATT*DW-1:0] att_o,
  output logic [NUM_ATT-1:0]    mute_o,
  output byte_t                 clk_cfg_o,
  output byte_t                 tx_fmt_o,
  output byte_t                 rx_fmt_o
);
  localparam addr_t LAST_ATT = addr_t'(NUM_ATT);

  byte_t att_q [NUM_ATT];

  for (genvar g = 0; g < NUM_ATT; g++) begin : g_att
    always_ff @(posedge clk) begin
      if (rst)
        att_q[g] <= '0;
      else if (wr_stb && (addr == addr_t'(g + 1) || addr == A_BCAST))
        att_q[g] <= wr_data;
    end
    assign att_o[g*DW +: DW] = att_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mute_o    <= '0;
      clk_cfg_o <= '0;
      tx_fmt_o  <= '0;
      rx_fmt_o  <= '0;
    end else if (wr_stb) begin
      case (addr)
        A_MUTE: mute_o    <= wr_data[NUM_ATT-1:0];
        A_CLK:  clk_cfg_o <= wr_data;
        A_TXF:  tx_fmt_o  <= wr_data;
        A_RXF:  rx_fmt_o  <= wr_data;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_ATT; i++)
      if (addr == addr_t'(i + 1)) rd_data = att_q[i];
    case (addr)
      A_MUTE: begin
        rd_data[NUM_ATT-1:0] = mute_o;
        rd_data[NUM_ATT]     = busy;
      end
      A_CLK: rd_data = clk_cfg_o;
      A_TXF: rd_data = tx_fmt_o;
      A_RXF: rd_data = rx_fmt_o;
      default: ;
    endcase
  end

  assign rd_ok = has_content(addr, LAST_ATT);
endmodule

// File: rtl/audio_ctl_spi.sv
module audio_ctl_spi
  import spi_regs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_ATT     = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sck,
  input  logic                  csn,
  input  logic                  mosi,
  output logic                  miso,
  input  logic [7:0]            status_in,
  input  logic                  busy,
  output logic [NUM_ATT*8-1:0]  att_o,
  output logic [NUM_ATT-1:0]    mute_o,
  output logic [7:0]            clk_cfg_o,
  output logic [7:0]            tx_fmt_o,
  output logic [7:0]            rx_fmt_o
);
  logic  sck_rise, sck_fall, cs_active, cs_fall, mosi_s;
  logic  byte_done, wr_stb, rd_ok;
  byte_t rx_byte, reply, wr_data, rd_data;
  addr_t ptr;

  spi_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_active(cs_active),
    .cs_fall(cs_fall), .mosi_s(mosi_s)
  );

  spi_shifter u_shift (
    .clk(clk), .rst(rst), .cs_active(cs_active), .cs_fall(cs_fall),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s),
    .reply(reply), .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso)
  );

  spi_frame_ctl u_frame (
    .clk(clk), .rst(rst), .cs_active(cs_active), .byte_done(byte_done),
    .rx_byte(rx_byte), .status_in(status_in), .rd_data(rd_data),
    .rd_ok(rd_ok), .ptr(ptr), .wr_stb(wr_stb), .wr_data(wr_data),
    .reply(reply)
  );

  audio_reg_bank #(.NUM_ATT(NUM_ATT)) u_bank (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .addr(ptr), .wr_data(wr_data),
    .busy(busy), .rd_data(rd_data), .rd_ok(rd_ok), .att_o(att_o),
    .mute_o(mute_o), .clk_cfg_o(clk_cfg_o), .tx_fmt_o(tx_fmt_o),
    .rx_fmt_o(rx_fmt_o)
  );
endmodule

// File: rtl/audio_ctl_spi_chk.sv
module audio_ctl_spi_chk #(
  parameter int NUM_ATT = 6
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 miso,
  input logic                 cs_active,
  input logic                 cs_fall,
  input logic                 sck_fall,
  input logic                 wr_stb,
  input logic [3:0]           wr_addr,
  input logic [7:0]           wr_data,
  input logic [NUM_ATT*8-1:0] att_o,
  input logic [NUM_ATT-1:0]   mute_o
);
  // R9
  idle_miso_low_chk: assert property (@(posedge clk) disable iff (rst)
    !cs_active |=> (miso == 1'b0));

  // R10
  miso_edge_only_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(miso) |-> $past(sck_fall || cs_fall || !cs_active));

  // R2
  ptr_advance_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> (wr_addr == $past(wr_addr) + 4'd1));

  // R6
  broadcast_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == 4'd7) |=> (att_o == {NUM_ATT{$past(wr_data)}}));

  // R7
  mute_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_stb |=> $stable(mute_o));

  // R7
  mute_store_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && wr_addr == 4'd8) |=> (mute_o == $past(wr_data[NUM_ATT-1:0])));
endmodule

bind audio_ctl_spi audio_ctl_spi_chk #(.NUM_ATT(NUM_ATT)) u_chk (
  .clk(clk), .rst(rst), .miso(miso), .cs_active(cs_active),
  .cs_fall(cs_fall), .sck_fall(sck_fall), .wr_stb(wr_stb),
  .wr_addr(ptr), .wr_data(wr_data), .att_o(att_o), .mute_o(mute_o)
);

// File: tb/audio_ctl_spi_test.sv
`timescale 1ns/1ps
module audio_ctl_spi_test;
  localparam int HALF = 40;
  localparam logic [7:0] STAT = 8'hA5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, csn = 1'b1, mosi = 1'b0, busy = 1'b0;
  logic [7:0] status_in = STAT;
  logic miso;
  logic [47:0] att_o;
  logic [5:0]  mute_o;
  logic [7:0]  clk_cfg_o, tx_fmt_o, rx_fmt_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] tx_buf [16];
  logic [7:0] rx_buf [16];

  always #2.5 clk = ~clk;

  audio_ctl_spi uut (
    .clk(clk), .rst(rst), .sck(sck), .csn(csn), .mosi(mosi), .miso(miso),
    .status_in(status_in), .busy(busy), .att_o(att_o), .mute_o(mute_o),
    .clk_cfg_o(clk_cfg_o), .tx_fmt_o(tx_fmt_o), .rx_fmt_o(rx_fmt_o)
  );

  // rows: {command, data byte, expected reply on data byte}
  localparam logic [23:0] VEC [15] = '{
    24'h03_11_A5,  // R2 write addr 1
    24'h02_00_11,  // R3 read addr 1
    24'h13_3C_A5,  // R2 write addr 9
    24'h12_00_3C,  // R3 read addr 9
    24'h15_5A_A5,  // R2 write addr 10
    24'h14_00_5A,  // R3 read addr 10
    24'h17_C3_A5,  // R2 write addr 11
    24'h16_00_C3,  // R3 read addr 11
    24'h00_00_A5,  // R5 read reserved 0
    24'h1A_00_A5,  // R5 read missing 13
    24'h0E_00_A5,  // R5 read write-only 7
    24'hE2_00_11,  // R1 upper command bits ignored
    24'h18_00_A5,  // R5 read addr 12
    24'h11_FF_A5,  // R7 write mute
    24'h10_00_3F   // R7 read mute, busy low
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input int nbytes, input int extra_bits);
    csn = 1'b0;
    for (int b = 0; b < nbytes; b++) begin
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_buf[b][i];
        #(HALF);
        rx_buf[b][i] = miso;
        sck = 1'b1;
        #(HALF);
        sck = 1'b0;
      end
    end
    for (int i = 0; i < extra_bits; i++) begin
      mosi = 1'b1;
      #(HALF);
      sck = 1'b1;
      #(HALF);
      sck = 1'b0;
    end
    #(HALF);
    csn = 1'b1;
    #(4*HALF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(100);
    rst = 1'b0;
    #(200);
    // R9 reset state
    chk("R9 att after reset", att_o, 48'h0);
    chk("R9 mute after reset", mute_o, 6'h0);
    chk("R9 miso idle", miso, 1'b0);

    for (int k = 0; k < 15; k++) begin
      tx_buf[0] = VEC[k][23:16];
      tx_buf[1] = VEC[k][15:8];
      run_frame(2, 0);
      chk($sformatf("R4 command reply row %0d", k), rx_buf[0], STAT);
      chk($sformatf("R1/R3/R5 data reply row %0d", k), rx_buf[1], VEC[k][7:0]);
    end
    chk("R2 clk cfg port", clk_cfg_o, 8'h3C);
    chk("R7 mute port", mute_o, 6'h3F);
    chk("R9 miso low between frames", miso, 1'b0);

    // R6 broadcast, then R3 burst read of all six
    tx_buf[0] = 8'h0F; tx_buf[1] = 8'h77;
    run_frame(2, 0);
    chk("R6 all attenuators", att_o, {6{8'h77}});
    tx_buf[0] = 8'h02;
    for (int b = 1; b < 7; b++) tx_buf[b] = 8'h00;
    run_frame(7, 0);
    for (int b = 1; b < 7; b++)
      chk($sformatf("R3 burst read byte %0d", b), rx_buf[b], 8'h77);

    // R2 write burst across 9..11, R4 replies
    tx_buf[0] = 8'h13; tx_buf[1] = 8'h01; tx_buf[2] = 8'h02; tx_buf[3] = 8'h03;
    run_frame(4, 0);
    chk("R2 burst addr 9", clk_cfg_o, 8'h01);
    chk("R2 burst addr 10", tx_fmt_o, 8'h02);
    chk("R2 burst addr 11", rx_fmt_o, 8'h03);
    chk("R4 write data reply", rx_buf[3], STAT);

    // R2 wrap 15 -> 0 -> 1
    tx_buf[0] = 8'h1F; tx_buf[1] = 8'h99; tx_buf[2] = 8'h88; tx_buf[3] = 8'h42;
    run_frame(4, 0);
    chk("R2 wrap lands on addr 1", att_o[7:0], 8'h42);
    chk("R2 wrap leaves addr 2", att_o[15:8], 8'h77);

    // R7 busy flag read and not writable
    busy = 1'b1;
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h00;
    run_frame(2, 0);
    chk("R7 busy reads bit 6", rx_buf[1], 8'h7F);
    busy = 1'b0;
    tx_buf[0] = 8'h11; tx_buf[1] = 8'h40;
    run_frame(2, 0);
    chk("R7 mute after bit6 write", mute_o, 6'h00);
    tx_buf[0] = 8'h10; tx_buf[1] = 8'h00;
    run_frame(2, 0);
    chk("R7 bit 6 not stored", rx_buf[1], 8'h00);

    // R8 aborted data byte is dropped, next frame restarts
    tx_buf[0] = 8'h03;
    run_frame(1, 4);
    chk("R8 partial byte dropped", att_o[7:0], 8'h42);
    tx_buf[0] = 8'h02; tx_buf[1] = 8'h00;
    run_frame(2, 0);
    chk("R8 new frame command reply", rx_buf[0], STAT);
    chk("R8 new frame read", rx_buf[1], 8'h42);

    finish_run();
  end
endmodule